// File: doc/BRIEF.md
# Transfer Data FIFO with Fill and Threshold Reporting

This block is the word buffer between a host-side data register and the serial data engine of a memory-card controller. It stores up to sixteen 32-bit words. A direction input chooses which side fills it. In the read direction the serial engine pushes and the host pops. In the write direction the host pushes and the serial engine pops.

Software controls the block through two register images. The control image holds the live fill level and two 5-bit watermarks, one for each direction. The status image holds a data-ready flag, which tells software a burst of the chosen size can be moved without polling each word. It also holds a sticky access-error bit, raised when a push is lost or a pop finds nothing. Software clears that bit by writing a one to it.

Top module: `sd_xfer_fifo`

## Requirements
- R1: Words leave in the order they entered, 32 bits each, up to 16 stored. The popped word appears on both read-data outputs on the clock edge that performs the pop and is held until the next pop.
- R2: The control image reports the fill level, 0 to 16, in bits 8:4.
- R3: The control image holds the write-direction watermark in bits 13:9 and the read-direction watermark in bits 18:14. Both load on a control write, both reset to 4, and all other written bits are ignored.
- R4: With dir_rd high the serial side pushes and the host pops. With dir_rd low the host pushes and the serial side pops. Push and pop strobes from the side not selected have no effect.
- R5: In the read direction, status bit 0 is 1 exactly when the fill level is at least the read watermark.
- R6: In the write direction, status bit 0 is 1 exactly when the free space (16 minus fill) is at least the write watermark.
- R7: A watermark of 0 behaves as 1.
- R8: A push into a full FIFO without a pop in the same cycle is discarded: the fill stays 16, the stored words are unchanged, and status bit 3 is set.
- R9: A pop from an empty FIFO without a push in the same cycle leaves the read data and the fill unchanged and sets status bit 3.
- R10: A push and a pop in the same cycle leave the fill unchanged and raise no error, even when the FIFO is full or empty. When it is empty, the pop returns the word pushed in that cycle.
- R11: Status bit 3 is cleared by a status write with bit 3 at 1. A status write with bit 3 at 0 has no effect on it. If a new access error occurs in the same cycle as the clear, the bit stays set.
- R12: After reset the fill is 0, status bit 3 is 0 and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_rd | input | 1 | 1 = read direction (serial side fills), 0 = write direction (host fills) |
| host_push | input | 1 | Host write strobe on the data register |
| host_pop | input | 1 | Host read strobe on the data register |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Last popped word, host view |
| ser_push | input | 1 | Serial engine push strobe |
| ser_pop | input | 1 | Serial engine pop strobe |
| ser_wdata | input | 32 | Serial engine push word |
| ser_rdata | output | 32 | Last popped word, serial view |
| cfg_we | input | 1 | Control image write strobe |
| cfg_wdata | input | 32 | Control image write value |
| cfg_rdata | output | 32 | Control image: fill and watermarks |
| sts_we | input | 1 | Status image write strobe (write-one-to-clear) |
| sts_wdata | input | 32 | Status image write value |
| sts_rdata | output | 32 | Status image: bit 0 data flag, bit 3 access error |

## Verification
The data-ready flag is swept over every fill level from empty to full against every watermark from 0 to 17, in both directions. This separates the fill comparison from the free-space comparison, shows a zero watermark acting as one, and shows a watermark above 16 acting as never met. Each sweep drains the FIFO and compares every word, so ordering and pointer wrap are covered on every pass. Separate sequences push into a full FIFO, pop from an empty one, and pulse the strobes of the side not selected. These show that a lost access changes neither contents nor level, while the error bit behaves differently for a one write, a zero write and a same-cycle new error. Same-cycle push and pop is tried both at empty, where the pushed word passes straight through, and at full, where the order must stay intact.

// File: rtl/sd_xfer_fifo.sv
module sd_xfer_fifo #(
  parameter int DEPTH   = 16,
  parameter int WIDTH   = 32,
  parameter int THR_W   = 5,
  parameter int THR_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_rd,
  input  logic             host_push,
  input  logic             host_pop,
  input  logic [WIDTH-1:0] host_wdata,
  output logic [WIDTH-1:0] host_rdata,
  input  logic             ser_push,
  input  logic             ser_pop,
  input  logic [WIDTH-1:0] ser_wdata,
  output logic [WIDTH-1:0] ser_rdata,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             sts_we,
  input  logic [31:0]      sts_wdata,
  output logic [31:0]      sts_rdata
);

  // DEPTH must be a power of two so the pointers wrap by themselves.
  localparam int AW       = $clog2(DEPTH);
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int FILL_LSB = 4;
  localparam int WTHR_LSB = FILL_LSB + THR_W;
  localparam int RTHR_LSB = WTHR_LSB + THR_W;
  localparam int ERR_BIT  = 3;
  localparam int FLAG_BIT = 0;
  localparam logic [CW-1:0]    FULL_CNT = CW'(DEPTH);
  localparam logic [THR_W-1:0] THR_ONE  = THR_W'(1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic [WIDTH-1:0] rdata_q;
  logic [THR_W-1:0] wthr, rthr;
  logic             err;

  logic             push, pop, empty, full;
  logic             do_wr, do_rd, bypass, rd_adv, overflow, underflow;
  logic [WIDTH-1:0] wdata;
  logic [THR_W-1:0] fill_f, free_f, wthr_eff, rthr_eff;
  logic             flag;

  assign push  = dir_rd ? ser_push  : host_push;
  assign pop   = dir_rd ? host_pop  : ser_pop;
  assign wdata = dir_rd ? ser_wdata : host_wdata;
  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);

  assign do_wr     = push & (~full | pop);
  assign do_rd     = pop & ~empty;
  assign bypass    = pop & empty & push;
  assign rd_adv    = do_rd | bypass;
  assign overflow  = push & full & ~pop;
  assign underflow = pop & empty & ~push;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      rdata_q <= '0;
    end else begin
      if (do_wr)  wptr <= wptr + AW'(1);
      if (rd_adv) rptr <= rptr + AW'(1);
      count <= count + CW'(do_wr) - CW'(rd_adv);
      if (do_rd)       rdata_q <= mem[rptr];
      else if (bypass) rdata_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wthr <= THR_W'(THR_RST);
      rthr <= THR_W'(THR_RST);
      err  <= 1'b0;
    end else begin
      if (cfg_we) begin
        wthr <= cfg_wdata[WTHR_LSB +: THR_W];
        rthr <= cfg_wdata[RTHR_LSB +: THR_W];
      end
      if (overflow | underflow)          err <= 1'b1;
      else if (sts_we && sts_wdata[ERR_BIT]) err <= 1'b0;
    end
  end

  assign fill_f   = THR_W'(count);
  assign free_f   = THR_W'(DEPTH) - fill_f;
  assign wthr_eff = (wthr == '0) ? THR_ONE : wthr;
  assign rthr_eff = (rthr == '0) ? THR_ONE : rthr;
  assign flag     = dir_rd ? (fill_f >= rthr_eff) : (free_f >= wthr_eff);

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[FILL_LSB +: THR_W] = fill_f;
    cfg_rdata[WTHR_LSB +: THR_W] = wthr;
    cfg_rdata[RTHR_LSB +: THR_W] = rthr;
    sts_rdata = '0;
    sts_rdata[FLAG_BIT] = flag;
    sts_rdata[ERR_BIT]  = err;
  end

  assign host_rdata = rdata_q;
  assign ser_rdata  = rdata_q;

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata, sts_wdata};

  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  a_r8_full_push_lost: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> (full && err && $stable(wptr)));

  a_r9_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> (empty && err && $stable(host_rdata) && $stable(rptr)));

  a_r10_pushpop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));

  a_r11_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && sts_wdata[ERR_BIT] && !overflow && !underflow) |=> !sts_rdata[ERR_BIT]);

  a_r11_w0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(sts_we && sts_wdata[ERR_BIT])) |=> err);

endmodule

// File: tb/sd_xfer_fifo_bench.sv
module sd_xfer_fifo_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, dir_rd;
  logic        host_push, host_pop, ser_push, ser_pop;
  logic [31:0] host_wdata, ser_wdata, host_rdata, ser_rdata;
  logic        cfg_we, sts_we;
  logic [31:0] cfg_wdata, cfg_rdata, sts_wdata, sts_rdata;

  int total = 0;
  int bad   = 0;

  sd_xfer_fifo u_sd_xfer_fifo (
    .clk(clk), .rst_n(rst_n), .dir_rd(dir_rd),
    .host_push(host_push), .host_pop(host_pop),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ser_push(ser_push), .ser_pop(ser_pop),
    .ser_wdata(ser_wdata), .ser_rdata(ser_rdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata)
  );

  function automatic logic [31:0] pat(int i);
    return 32'h5A00_0000 ^ (32'(i) * 32'h0103_0507);
  endfunction

  function automatic int fill();
    return int'((cfg_rdata >> 4) & 32'h1F);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic cyc(bit hpu, bit hpo, bit spu, bit spo, logic [31:0] hw, logic [31:0] sw);
    host_push = hpu; host_pop = hpo; ser_push = spu; ser_pop = spo;
    host_wdata = hw; ser_wdata = sw;
    @(negedge clk);
    host_push = 0; host_pop = 0; ser_push = 0; ser_pop = 0;
  endtask

  task automatic set_thr(int w, int r);
    cfg_wdata = {13'h1ABC, 5'(r), 5'(w), 9'h1FF};
    cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic sts_write(bit one);
    sts_wdata = one ? 32'h0000_0008 : 32'hFFFF_FFF7;
    sts_we = 1;
    @(negedge clk);
    sts_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; dir_rd = 0;
    host_push = 0; host_pop = 0; ser_push = 0; ser_pop = 0;
    host_wdata = '0; ser_wdata = '0;
    cfg_we = 0; cfg_wdata = '0; sts_we = 0; sts_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12 / R3 reset state
    chk("R12 fill", 32'(fill()), 0);
    chk("R12 err", {31'b0, sts_rdata[3]}, 0);
    chk("R12 rdata", host_rdata, 0);
    chk("R3 reset image", cfg_rdata, (32'd4 << 14) | (32'd4 << 9));
    chk("R6 reset flag", {31'b0, sts_rdata[0]}, 1);

    // R3 field load, junk in other bits ignored
    set_thr(7, 19);
    chk("R3 image", cfg_rdata, (32'd19 << 14) | (32'd7 << 9));

    // R4/R1/R8 write direction: host fills, foreign strobes ignored
    dir_rd = 0;
    for (int i = 0; i < 16; i++) begin
      cyc(1, 0, 1, 0, pat(i), 32'hDEAD_BEEF);
      chk("R2 fill", 32'(fill()), 32'(i + 1));
    end
    cyc(0, 1, 0, 0, '0, '0);
    chk("R4 host pop ignored fill", 32'(fill()), 16);
    chk("R4 host pop ignored err", {31'b0, sts_rdata[3]}, 0);
    cyc(1, 0, 0, 0, 32'hBAD0_0000, '0);
    chk("R8 fill", 32'(fill()), 16);
    chk("R8 err", {31'b0, sts_rdata[3]}, 1);
    sts_write(0);
    chk("R11 zero write keeps", {31'b0, sts_rdata[3]}, 1);
    sts_write(1);
    chk("R11 clear", {31'b0, sts_rdata[3]}, 0);
    for (int i = 0; i < 16; i++) begin
      cyc(0, 0, 0, 1, '0, '0);
      chk("R1 order", ser_rdata, pat(i));
      chk("R1 both views", host_rdata, pat(i));
    end
    cyc(0, 0, 0, 1, '0, '0);
    chk("R9 rdata held", ser_rdata, pat(15));
    chk("R9 fill", 32'(fill()), 0);
    chk("R9 err", {31'b0, sts_rdata[3]}, 1);
    // R11: new error in same cycle as clear wins
    sts_wdata = 32'h8; sts_we = 1;
    cyc(0, 0, 0, 1, '0, '0);
    sts_we = 0;
    chk("R11 set wins", {31'b0, sts_rdata[3]}, 1);
    sts_write(1);
    // pointers unmoved after underflow: next word pushed is next popped
    cyc(1, 0, 0, 0, 32'h0F0F_1234, '0);
    cyc(0, 0, 0, 1, '0, '0);
    chk("R9 pointers unmoved", ser_rdata, 32'h0F0F_1234);

    // R10 simultaneous at empty (read direction, bypass)
    dir_rd = 1;
    cyc(0, 1, 1, 0, '0, 32'hCAFE_0001);
    chk("R10 empty bypass data", host_rdata, 32'hCAFE_0001);
    chk("R10 empty fill", 32'(fill()), 0);
    chk("R10 empty err", {31'b0, sts_rdata[3]}, 0);
    cyc(0, 0, 0, 1, '0, '0);
    chk("R4 ser pop ignored", 32'(fill()), 0);
    chk("R4 ser pop no err", {31'b0, sts_rdata[3]}, 0);
    // R10 simultaneous at full
    for (int i = 0; i < 16; i++) cyc(1, 0, 1, 0, 32'hBAD1_0000, pat(100 + i));
    chk("R4 host push ignored", 32'(fill()), 16);
    cyc(0, 1, 1, 0, '0, pat(200));
    chk("R10 full fill", 32'(fill()), 16);
    chk("R10 full err", {31'b0, sts_rdata[3]}, 0);
    chk("R10 full data", host_rdata, pat(100));
    for (int i = 1; i < 17; i++) begin
      cyc(0, 1, 0, 0, '0, '0);
      chk("R10 order kept", host_rdata, (i < 16) ? pat(100 + i) : pat(200));
    end

    // R5/R7 read-direction watermark sweep
    dir_rd = 1;
    for (int t = 0; t < 18; t++) begin
      set_thr(31, t);
      for (int lvl = 0; lvl <= 16; lvl++) begin
        chk("R2 sweep fill", 32'(fill()), 32'(lvl));
        chk("R5 R7 flag", {31'b0, sts_rdata[0]}, {31'b0, lvl >= ((t == 0) ? 1 : t)});
        if (lvl < 16) cyc(0, 0, 1, 0, '0, pat(t * 32 + lvl));
      end
      for (int k = 0; k < 16; k++) begin
        cyc(0, 1, 0, 0, '0, '0);
        chk("R1 read drain", host_rdata, pat(t * 32 + k));
      end
    end

    // R6/R7 write-direction watermark sweep
    dir_rd = 0;
    for (int t = 0; t < 18; t++) begin
      set_thr(t, 31);
      for (int lvl = 0; lvl <= 16; lvl++) begin
        chk("R6 R7 flag", {31'b0, sts_rdata[0]}, {31'b0, (16 - lvl) >= ((t == 0) ? 1 : t)});
        if (lvl < 16) cyc(1, 0, 0, 0, pat(1000 + t * 32 + lvl), '0);
      end
      for (int k = 0; k < 16; k++) begin
        cyc(0, 0, 0, 1, '0, '0);
        chk("R1 write drain", ser_rdata, pat(1000 + t * 32 + k));
      end
    end
    chk("R8 R9 no stray error", {31'b0, sts_rdata[3]}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule